// File: doc/BRIEF.md
# Resume-Time Saved-State Legality Checker

When a processor leaves its system management mode it reloads control, debug and mode registers from a save area. This block inspects those restored images before they take effect. The images arrive one at a time over a valid/ready stream, each tagged with a field identifier, and may come in any order. Once every field has been captured exactly once, the block issues a single verdict: resume, or go to shutdown. It also returns the extended feature register value to be installed and says whether the four page-directory-pointer entries must be reloaded.

A start pulse opens a new check. It clears every captured field and samples two references: the current virtualization-enable state and the revision value recorded when the mode was entered. The verdict, a per-rule failure mask and the companion outputs are held until the consumer acknowledges them. A field identifier that is sent a second time raises an error flag, and that second copy is dropped.

Top module: `rsm_state_check`

## Requirements
- R1: While reset is applied and after it is released, fld_ready_o, verdict_valid_o and dup_err_o are 0. The block then waits for a start pulse.
- R2: After a start pulse, fld_ready_o is 1 until all eight field identifiers have been accepted, in any order. The identifiers are: 0 CR0, 1 CR3, 2 CR4, 3 DR6, 4 DR7, 5 extended feature register, 6 code segment (bit 0 = D, bit 1 = L), 7 revision. verdict_valid_o is still 0 after the clock edge that accepts the last field and becomes 1 after the following edge.
- R3: Rule bit 0 is set when CR0 has bit 31 (paging) = 1 and bit 0 (protection) = 0, unless the virtualization-enable value sampled at start is 1.
- R4: Rule bit 1 is set when CR0 bit 29 (no write-through) = 1 and CR0 bit 30 (cache disable) = 0.
- R5: Rule bit 2 is set when any bit of CR0, CR3, CR4, DR6, DR7 or the extended feature register falls within that register's reserved-bit mask parameter. By default, CR3 bit 63 and extended feature bit 1 are reserved.
- R6: Rule bit 3 is set when extended feature bit 8 (long mode enable) = 1, CR0 bit 31 = 1 and CR4 bit 5 (physical address extension) = 0.
- R7: Rule bit 4 is set when long mode enable = 1, CR0 bit 31 = 1, CR4 bit 5 = 1, and the code segment field has D = 1 and L = 1.
- R8: Rule bit 5 is set when the low REV_W bits of the revision field differ from entry_rev_i as sampled at start.
- R9: verdict_shutdown_o is 1 exactly when some rule bit is set. In efer_o, bit 12 (virtualization enable) equals the value sampled at start, whatever the restored image holds. All other bits of efer_o are the restored image.
- R10: pdpe_reload_o is 1 exactly when the verdict is resume, the sampled virtualization enable is 1, CR0 bit 31 = 1, CR4 bit 5 = 1 and long mode enable = 0.
- R11: An identifier that is accepted a second time before a new start sets dup_err_o, and the first captured value is kept. A start pulse clears dup_err_o.
- R12: All verdict outputs hold their values while no acknowledge arrives. verdict_valid_o falls after the edge that samples verdict_ack_i = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a new check, clear captured fields |
| virt_en_i | input | 1 | Current virtualization-enable state, sampled at start |
| entry_rev_i | input | REV_W | Revision recorded at mode entry, sampled at start |
| fld_valid_i | input | 1 | Field word valid |
| fld_ready_o | output | 1 | Block accepts a field word |
| fld_id_i | input | 3 | Field identifier |
| fld_data_i | input | DATA_W | Field image |
| verdict_valid_o | output | 1 | Verdict outputs are valid |
| verdict_shutdown_o | output | 1 | 1 = shutdown, 0 = resume |
| rule_fail_o | output | 6 | One bit per failed rule |
| pdpe_reload_o | output | 1 | Page-directory-pointer reload needed |
| efer_o | output | DATA_W | Extended feature value to install |
| dup_err_o | output | 1 | A field identifier arrived twice |
| verdict_ack_i | input | 1 | Consumer takes the verdict |

## Verification
A field is captured at the edge where valid and ready are both high. The duplicate flag is therefore due right after that edge. The verdict is due one edge later, because the rule results are registered into the hold state. The bench drives and samples on falling edges. After sending the last field it first confirms that verdict_valid_o is still 0, and then reads every verdict output one falling edge later. An acknowledge or a start takes effect at the next rising edge, so the outputs are checked on the falling edge that follows it.

// File: rtl/rsm_chk_pkg.sv
// Shared identifiers, bit positions and state encoding for the saved-state checker.
package rsm_chk_pkg;
    localparam int NUM_FIELDS = 8;
    localparam int FID_W      = 3;
    localparam int NUM_RULES  = 6;

    typedef enum logic [FID_W-1:0] {
        F_CR0  = 3'd0,
        F_CR3  = 3'd1,
        F_CR4  = 3'd2,
        F_DR6  = 3'd3,
        F_DR7  = 3'd4,
        F_EFER = 3'd5,
        F_CSEG = 3'd6,
        F_REV  = 3'd7
    } fid_e;

    // rule bit indices in the failure mask
    localparam int RB_PAGED_NOPROT = 0;
    localparam int RB_CACHE_COMBO  = 1;
    localparam int RB_RESERVED     = 2;
    localparam int RB_LONG_NOPAE   = 3;
    localparam int RB_LONG_CS      = 4;
    localparam int RB_REVISION     = 5;

    // architectural bit positions the rules decode
    localparam int CR0_PE    = 0;
    localparam int CR0_NW    = 29;
    localparam int CR0_CD    = 30;
    localparam int CR0_PG    = 31;
    localparam int CR4_PAE   = 5;
    localparam int EFER_LME  = 8;
    localparam int EFER_VIRT = 12;
    localparam int CS_D      = 0;
    localparam int CS_L      = 1;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_HOLD    = 2'd2
    } st_e;
endpackage

// File: rtl/rsm_field_capture.sv
// Field capture store.
// Holds one slot per field identifier and a received flag per slot.
// Assumes: clear_i and wr_en_i are never both meaningful in one cycle; clear_i wins.
// A write to an already filled slot leaves the slot unchanged and raises dup_o.
module rsm_field_capture
    import rsm_chk_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             clear_i,
    input  logic                             wr_en_i,
    input  logic [FID_W-1:0]                 wr_id_i,
    input  logic [DATA_W-1:0]                wr_data_i,
    output logic [NUM_FIELDS-1:0][DATA_W-1:0] fields_o,
    output logic [NUM_FIELDS-1:0]            have_o,
    output logic                             dup_o
);
    logic [NUM_FIELDS-1:0] hit;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_slot
        assign hit[g] = wr_en_i && (wr_id_i == FID_W'(g));

        // Store the first image written to this slot after a clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                fields_o[g] <= '0;
                have_o[g]   <= 1'b0;
            end else if (clear_i) begin
                fields_o[g] <= '0;
                have_o[g]   <= 1'b0;
            end else if (hit[g] && !have_o[g]) begin
                fields_o[g] <= wr_data_i;
                have_o[g]   <= 1'b1;
            end
        end
    end

    // Sticky flag for a write that lands on a slot that is already filled.
    always_ff @(posedge clk) begin
        if (!rst_n)       dup_o <= 1'b0;
        else if (clear_i) dup_o <= 1'b0;
        else if (|(hit & have_o)) dup_o <= 1'b1;
    end
endmodule

// File: rtl/rsm_rule_eval.sv
// Combinational legality rules over the captured images.
// Assumes: inputs are stable once every field has been received.
// virt_en_i is the live enable sampled at start, never the restored one.
module rsm_rule_eval
    import rsm_chk_pkg::*;
#(
    parameter int              DATA_W    = 64,
    parameter int              REV_W     = 32,
    parameter logic [DATA_W-1:0] RSV_CR0  = '0,
    parameter logic [DATA_W-1:0] RSV_CR3  = '0,
    parameter logic [DATA_W-1:0] RSV_CR4  = '0,
    parameter logic [DATA_W-1:0] RSV_DR6  = '0,
    parameter logic [DATA_W-1:0] RSV_DR7  = '0,
    parameter logic [DATA_W-1:0] RSV_EFER = '0
) (
    input  logic [NUM_FIELDS-1:0][DATA_W-1:0] fields_i,
    input  logic                              virt_en_i,
    input  logic [REV_W-1:0]                  rev_ref_i,
    output logic [NUM_RULES-1:0]              fail_o,
    output logic                              reload_o,
    output logic [DATA_W-1:0]                 efer_o
);
    localparam int NUM_RSV = 6;

    logic [DATA_W-1:0] cr0, cr4, efer, cseg, rev;
    logic              pg, pe, pae, lme;
    logic [NUM_RSV-1:0] rsv_hit;

    assign cr0  = fields_i[F_CR0];
    assign cr4  = fields_i[F_CR4];
    assign efer = fields_i[F_EFER];
    assign cseg = fields_i[F_CSEG];
    assign rev  = fields_i[F_REV];
    assign pg   = cr0[CR0_PG];
    assign pe   = cr0[CR0_PE];
    assign pae  = cr4[CR4_PAE];
    assign lme  = efer[EFER_LME];

    // Reserved-bit screen: one term per register that carries a mask.
    assign rsv_hit[0] = |(fields_i[F_CR0]  & RSV_CR0);
    assign rsv_hit[1] = |(fields_i[F_CR3]  & RSV_CR3);
    assign rsv_hit[2] = |(fields_i[F_CR4]  & RSV_CR4);
    assign rsv_hit[3] = |(fields_i[F_DR6]  & RSV_DR6);
    assign rsv_hit[4] = |(fields_i[F_DR7]  & RSV_DR7);
    assign rsv_hit[5] = |(fields_i[F_EFER] & RSV_EFER);

    // Cross-register rules, one bit each.
    always_comb begin
        fail_o = '0;
        fail_o[RB_PAGED_NOPROT] = pg && !pe && !virt_en_i;
        fail_o[RB_CACHE_COMBO]  = cr0[CR0_NW] && !cr0[CR0_CD];
        fail_o[RB_RESERVED]     = |rsv_hit;
        fail_o[RB_LONG_NOPAE]   = lme && pg && !pae;
        fail_o[RB_LONG_CS]      = lme && pg && pae && cseg[CS_D] && cseg[CS_L];
        fail_o[RB_REVISION]     = rev[REV_W-1:0] != rev_ref_i;
    end

    // Legacy physical-address-extension paging target with virtualization on.
    assign reload_o = virt_en_i && pg && pae && !lme && (fail_o == '0);

    // Restored image with the virtualization enable forced to the live value.
    always_comb begin
        efer_o            = efer;
        efer_o[EFER_VIRT] = virt_en_i;
    end
endmodule

// File: rtl/rsm_state_check.sv
// Top: stream intake, sequencing and verdict hold for the saved-state checker.
// Assumes: start_i is a single-cycle pulse; the consumer acknowledges with a
// single-cycle verdict_ack_i. Start overrides every other input.
module rsm_state_check
    import rsm_chk_pkg::*;
#(
    parameter int                DATA_W   = 64,
    parameter int                REV_W    = 32,
    parameter logic [DATA_W-1:0] RSV_CR0  = 64'hFFFF_FFFF_1FFA_FFC0,
    parameter logic [DATA_W-1:0] RSV_CR3  = 64'hFFF0_0000_0000_0FE7,
    parameter logic [DATA_W-1:0] RSV_CR4  = 64'hFFFF_FFFF_FFFF_F800,
    parameter logic [DATA_W-1:0] RSV_DR6  = 64'hFFFF_FFFF_0000_0000,
    parameter logic [DATA_W-1:0] RSV_DR7  = 64'hFFFF_FFFF_0000_0000,
    parameter logic [DATA_W-1:0] RSV_EFER = 64'hFFFF_FFFF_FFFF_82FE
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 virt_en_i,
    input  logic [REV_W-1:0]     entry_rev_i,
    input  logic                 fld_valid_i,
    output logic                 fld_ready_o,
    input  logic [2:0]           fld_id_i,
    input  logic [DATA_W-1:0]    fld_data_i,
    output logic                 verdict_valid_o,
    output logic                 verdict_shutdown_o,
    output logic [5:0]           rule_fail_o,
    output logic                 pdpe_reload_o,
    output logic [DATA_W-1:0]    efer_o,
    output logic                 dup_err_o,
    input  logic                 verdict_ack_i
);
    st_e                              state_q;
    logic                             virt_q;
    logic [REV_W-1:0]                 rev_ref_q;
    logic [NUM_FIELDS-1:0][DATA_W-1:0] fields;
    logic [NUM_FIELDS-1:0]            have;
    logic                             all_in;
    logic                             accept;
    logic [NUM_RULES-1:0]             fail_c, fail_q;
    logic                             reload_c, reload_q, shut_q;
    logic [DATA_W-1:0]                efer_c, efer_q;
    logic                             hold;

    assign all_in      = &have;
    assign fld_ready_o = (state_q == ST_COLLECT) && !all_in;
    assign accept      = fld_valid_i && fld_ready_o;
    assign hold        = state_q == ST_HOLD;

    rsm_field_capture #(.DATA_W(DATA_W)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (start_i),
        .wr_en_i   (accept),
        .wr_id_i   (fld_id_i),
        .wr_data_i (fld_data_i),
        .fields_o  (fields),
        .have_o    (have),
        .dup_o     (dup_err_o)
    );

    rsm_rule_eval #(
        .DATA_W(DATA_W), .REV_W(REV_W),
        .RSV_CR0(RSV_CR0), .RSV_CR3(RSV_CR3), .RSV_CR4(RSV_CR4),
        .RSV_DR6(RSV_DR6), .RSV_DR7(RSV_DR7), .RSV_EFER(RSV_EFER)
    ) u_rules (
        .fields_i  (fields),
        .virt_en_i (virt_q),
        .rev_ref_i (rev_ref_q),
        .fail_o    (fail_c),
        .reload_o  (reload_c),
        .efer_o    (efer_c)
    );

    // Sequencer: idle, collecting fields, holding a verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (start_i) begin
            state_q <= ST_COLLECT;
        end else begin
            case (state_q)
                ST_COLLECT: if (all_in) state_q <= ST_HOLD;
                ST_HOLD:    if (verdict_ack_i) state_q <= ST_IDLE;
                default:    state_q <= state_q;
            endcase
        end
    end

    // Reference values sampled when a check begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            virt_q    <= 1'b0;
            rev_ref_q <= '0;
        end else if (start_i) begin
            virt_q    <= virt_en_i;
            rev_ref_q <= entry_rev_i;
        end
    end

    // Verdict registers, loaded on the transition into the hold state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail_q   <= '0;
            shut_q   <= 1'b0;
            reload_q <= 1'b0;
            efer_q   <= '0;
        end else if (!start_i && state_q == ST_COLLECT && all_in) begin
            fail_q   <= fail_c;
            shut_q   <= |fail_c;
            reload_q <= reload_c;
            efer_q   <= efer_c;
        end
    end

    assign verdict_valid_o    = hold;
    assign verdict_shutdown_o = hold && shut_q;
    assign rule_fail_o        = hold ? fail_q : '0;
    assign pdpe_reload_o      = hold && reload_q;
    assign efer_o             = hold ? efer_q : '0;
endmodule

// File: rtl/rsm_state_check_sva.sv
// Property checker for rsm_state_check, attached by bind below.
// Assumes: it sees only the top-level ports.
module rsm_state_check_sva #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              virt_en_i,
    input logic              fld_valid_i,
    input logic              fld_ready_o,
    input logic              verdict_valid_o,
    input logic              verdict_shutdown_o,
    input logic [5:0]        rule_fail_o,
    input logic              pdpe_reload_o,
    input logic [DATA_W-1:0] efer_o,
    input logic              dup_err_o,
    input logic              verdict_ack_i
);
    logic virt_seen;

    // Track the enable value as it was at the most recent start.
    always_ff @(posedge clk) begin
        if (!rst_n)       virt_seen <= 1'b0;
        else if (start_i) virt_seen <= virt_en_i;
    end

    a_r2_no_intake_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid_o |-> !fld_ready_o);

    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!verdict_valid_o && !dup_err_o));

    a_r9_shutdown_matches_mask: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid_o |-> (verdict_shutdown_o == (rule_fail_o != 6'd0)));

    a_r9_virt_kept: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid_o |-> (efer_o[12] == virt_seen));

    a_r10_reload_on_resume: assert property (@(posedge clk) disable iff (!rst_n)
        pdpe_reload_o |-> (verdict_valid_o && !verdict_shutdown_o));

    a_r11_dup_needs_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dup_err_o) |-> $past(fld_valid_i && fld_ready_o));

    a_r12_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_valid_o && !verdict_ack_i && !start_i) |=>
        (verdict_valid_o && $stable(rule_fail_o) && $stable(efer_o) && $stable(pdpe_reload_o)));

    a_r12_ack_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_valid_o && verdict_ack_i && !start_i) |=> !verdict_valid_o);
endmodule

bind rsm_state_check rsm_state_check_sva #(.DATA_W(DATA_W)) u_sva (
    .clk                (clk),
    .rst_n              (rst_n),
    .start_i            (start_i),
    .virt_en_i          (virt_en_i),
    .fld_valid_i        (fld_valid_i),
    .fld_ready_o        (fld_ready_o),
    .verdict_valid_o    (verdict_valid_o),
    .verdict_shutdown_o (verdict_shutdown_o),
    .rule_fail_o        (rule_fail_o),
    .pdpe_reload_o      (pdpe_reload_o),
    .efer_o             (efer_o),
    .dup_err_o          (dup_err_o),
    .verdict_ack_i      (verdict_ack_i)
);

// File: tb/rsm_state_check_tb.sv
// Directed bench for rsm_state_check: one task per scenario.
module rsm_state_check_tb_top;
    localparam logic [31:0] REV = 32'h0003_0064;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        virt_en_i = 1'b0;
    logic [31:0] entry_rev_i = REV;
    logic        fld_valid_i = 1'b0;
    logic        fld_ready_o;
    logic [2:0]  fld_id_i = '0;
    logic [63:0] fld_data_i = '0;
    logic        verdict_valid_o, verdict_shutdown_o, pdpe_reload_o, dup_err_o;
    logic [5:0]  rule_fail_o;
    logic [63:0] efer_o;
    logic        verdict_ack_i = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    logic [63:0] img [8];

    always #5 clk = ~clk;

    rsm_state_check dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .virt_en_i(virt_en_i),
        .entry_rev_i(entry_rev_i), .fld_valid_i(fld_valid_i), .fld_ready_o(fld_ready_o),
        .fld_id_i(fld_id_i), .fld_data_i(fld_data_i), .verdict_valid_o(verdict_valid_o),
        .verdict_shutdown_o(verdict_shutdown_o), .rule_fail_o(rule_fail_o),
        .pdpe_reload_o(pdpe_reload_o), .efer_o(efer_o), .dup_err_o(dup_err_o),
        .verdict_ack_i(verdict_ack_i)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Legal long-mode image set.
    task automatic set_base();
        img[0] = 64'h8000_0011;
        img[1] = 64'h0000_1000;
        img[2] = 64'h0000_0020;
        img[3] = 64'hFFFF_0FF0;
        img[4] = 64'h0000_0400;
        img[5] = 64'h0000_0500;
        img[6] = 64'h2;
        img[7] = {32'h0, REV};
    endtask

    task automatic do_start(input logic virt);
        start_i = 1'b1; virt_en_i = virt;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic send(input int id, input logic [63:0] data);
        fld_valid_i = 1'b1; fld_id_i = 3'(id); fld_data_i = data;
        while (!fld_ready_o) @(negedge clk);
        @(negedge clk);
        fld_valid_i = 1'b0;
    endtask

    task automatic run_case(input string tag, input logic virt, input bit rev_order,
                            input logic [5:0] exp_fail, input logic exp_reload,
                            input logic [63:0] exp_efer, input int hold_cycles);
        do_start(virt);
        for (int i = 0; i < 8; i++) send(rev_order ? 7 - i : i, img[rev_order ? 7 - i : i]);
        chk({tag, " R2 not yet valid"}, verdict_valid_o, 0);
        @(negedge clk);
        chk({tag, " R2 valid"}, verdict_valid_o, 1);
        chk({tag, " rule mask"}, rule_fail_o, exp_fail);
        chk({tag, " R9 shutdown"}, verdict_shutdown_o, exp_fail != 0);
        chk({tag, " R10 reload"}, pdpe_reload_o, exp_reload);
        chk({tag, " R9 efer"}, efer_o, exp_efer);
        repeat (hold_cycles) @(negedge clk);
        chk({tag, " R12 held valid"}, verdict_valid_o, 1);
        chk({tag, " R12 held mask"}, rule_fail_o, exp_fail);
        verdict_ack_i = 1'b1;
        @(negedge clk);
        verdict_ack_i = 1'b0;
        chk({tag, " R12 ack drops"}, verdict_valid_o, 0);
    endtask

    task automatic t_reset();
        chk("R1 ready in reset", fld_ready_o, 0);
        chk("R1 valid in reset", verdict_valid_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", fld_ready_o, 0);
        chk("R1 dup after reset", dup_err_o, 0);
    endtask

    task automatic t_legal();
        set_base(); run_case("R2 fwd", 0, 0, 6'h00, 0, 64'h500, 0);
        set_base(); run_case("R2 rev", 0, 1, 6'h00, 0, 64'h500, 4);
    endtask

    task automatic t_rules();
        set_base(); img[0] = 64'h8000_0010; run_case("R3 paged noprot", 0, 0, 6'h01, 0, 64'h500, 0);
        set_base(); img[0] = 64'h8000_0010; run_case("R3 relaxed", 1, 0, 6'h00, 0, 64'h1500, 0);
        set_base(); img[0] = 64'hA000_0011; run_case("R4 nw", 0, 1, 6'h02, 0, 64'h500, 0);
        set_base(); img[1] = 64'h8000_0000_0000_1000; run_case("R5 cr3", 0, 0, 6'h04, 0, 64'h500, 0);
        set_base(); img[5] = 64'h502; run_case("R5 efer", 0, 0, 6'h04, 0, 64'h502, 0);
        set_base(); img[2] = 64'h0; run_case("R6 nopae", 0, 0, 6'h08, 0, 64'h500, 0);
        set_base(); img[6] = 64'h3; run_case("R7 cs", 0, 1, 6'h10, 0, 64'h500, 0);
        set_base(); img[7] = 64'h1234; run_case("R8 rev", 0, 0, 6'h20, 0, 64'h500, 0);
    endtask

    task automatic t_virt();
        set_base(); img[5] = 64'h1500; run_case("R9 saved set", 0, 0, 6'h00, 0, 64'h500, 0);
        set_base(); img[5] = 64'h0; run_case("R10 reload", 1, 0, 6'h00, 1, 64'h1000, 0);
        set_base(); img[5] = 64'h0; run_case("R10 no virt", 0, 0, 6'h00, 0, 64'h0, 0);
    endtask

    task automatic t_dup();
        set_base();
        do_start(0);
        send(0, img[0]);
        chk("R11 no dup yet", dup_err_o, 0);
        send(0, 64'hA000_0011);
        chk("R11 dup flagged", dup_err_o, 1);
        for (int i = 1; i < 8; i++) send(i, img[i]);
        @(negedge clk);
        chk("R11 first kept", rule_fail_o, 6'h00);
        do_start(0);
        chk("R11 start clears dup", dup_err_o, 0);
        chk("R2 start reopens", fld_ready_o, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_legal();
        t_rules();
        t_virt();
        t_dup();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule